// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block watches the stream of byte-load events that a separate bus sequencer takes from a parallel flash interface. It picks out the keyed command sequences in that stream. Every command opens with two fixed key bytes, and its third byte selects the action. The extended form repeats the key pair after an 80h escape byte, which gives a six-byte sequence. From these sequences the decoder keeps a write-protection flag, a product-identification mode and lock flags for two 16 KB boot regions: one at the bottom of the address space and one at the top.

Any load that is not part of a command belongs to a sector load window. When the sequencer reports that the load period has ended, the decoder gives a verdict for that window. It either lets the program cycle change the array or lets the cycle run its timer with nothing written. Changes to protection wait for the end of the program period that follows. While identification mode is on, the read path returns fixed codes and lock status in place of array data.

The protection and lock flags come up clear at power-up and are left untouched by the synchronous reset. The reset clears identification mode and any partly decoded sequence.

Top module: `unlock_seq_decoder`

## Requirements
- R1: A command opens with AAh loaded at command address 5555h and then 55h loaded at 2AAAh. Only address bits 14..0 take part in command matching, so higher address bits are ignored.
- R2: Third byte A0h at 5555h opens an authorised sector load. Once the window holds data, load_end produces a one-cycle sect_write pulse in the cycle after the load_end edge.
- R3: A write opened by A0h sets prot_on at the edge that samples the next prog_end, and not before. A window that closes with no data bytes sets nothing.
- R4: With prot_on low, an unprefixed sector load ends in sect_write. With prot_on high, it ends in a one-cycle sect_skip pulse instead.
- R5: The sequence AA, 55, 80h, AA, 55, 20h, followed by a sector load, ends in sect_write and clears prot_on at the next prog_end.
- R6: Third byte 90h sets id_mode, which is visible after the edge that takes the byte. In id_mode, rd_data one cycle after rd_addr = 0 is 1Fh, and after rd_addr = 1 it is A4h.
- R7: Third byte F0h clears id_mode.
- R8: The extended sequence with sixth byte 40h, then 00h at address 0, sets lock_lo. The same sequence then FFh at the all-ones address sets lock_hi. Each lock is independent, and once set it stays set.
- R9: In id_mode, address 2 reports the lower region and the top region base plus 2 reports the upper one. The value is FFh when that region is locked and FEh when it is not. Outside id_mode, rd_data is arr_rdata delayed by one cycle.
- R10: A sector load window with any byte inside a locked region ends in sect_skip, even when it was authorised.
- R11: A byte that breaks a sequence returns the decoder to idle and counts as the first data byte of an unprefixed load. load_end always returns the decoder to idle. A window with no data gives no verdict.
- R12: The extended sequence with sixth byte 10h produces a one-cycle erase_go pulse only while neither region is locked.
- R13: rst clears id_mode and any partial sequence, and keeps prot_on, lock_lo and lock_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | One-cycle byte-load event |
| ld_addr | input | 19 | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| load_end | input | 1 | Load period ended, program period starts |
| prog_end | input | 1 | Program period ended |
| rd_addr | input | 19 | Read address |
| arr_rdata | input | 8 | Array data for rd_addr |
| sect_write | output | 1 | Verdict pulse: program cycle writes |
| sect_skip | output | 1 | Verdict pulse: program cycle runs with no data change |
| erase_go | output | 1 | Whole-array erase request pulse |
| prot_on | output | 1 | Write protection active |
| id_mode | output | 1 | Identification mode active |
| lock_lo | output | 1 | Lower boot region locked |
| lock_hi | output | 1 | Upper boot region locked |
| rd_data | output | 8 | Registered read data |

## Verification
Some properties are checked on every cycle. Protection moves only on a prog_end edge, and the lock flags never fall. load_end always leaves the decoder idle, and a locked-region hit stays recorded until the window closes. The manufacturer code and the array pass-through are checked on the read path. Other behaviour can only be shown by bench scenarios that drive whole sequences. These include the sequence matching and the verdicts for prefixed and unprefixed windows, with protection on and off. They also cover a broken sequence falling back to data, reset in the middle of a sequence, and the refusal to erase once a region is locked.

// File: rtl/usd_pkg.sv
package usd_pkg;
  localparam int CMD_W = 15;
  localparam logic [CMD_W-1:0] KEY_A = 15'h5555;
  localparam logic [CMD_W-1:0] KEY_B = 15'h2AAA;
  localparam logic [7:0] D_KA       = 8'hAA;
  localparam logic [7:0] D_KB       = 8'h55;
  localparam logic [7:0] OP_PROT_ON = 8'hA0;
  localparam logic [7:0] OP_EXT     = 8'h80;
  localparam logic [7:0] OP_ID_IN   = 8'h90;
  localparam logic [7:0] OP_ID_OUT  = 8'hF0;
  localparam logic [7:0] OP_PROT_OF = 8'h20;
  localparam logic [7:0] OP_LOCK    = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h10;
  localparam logic [7:0] ID_MFR     = 8'h1F;
  localparam logic [7:0] ID_DEV     = 8'hA4;
  localparam logic [7:0] ST_OPEN    = 8'hFE;
  localparam logic [7:0] ST_SHUT    = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_C1, ST_C2, ST_C3, ST_C4, ST_C5, ST_LOCK, ST_DATA
  } seq_st_e;

  typedef enum logic [1:0] {WK_PLAIN, WK_SET, WK_CLR} win_kind_e;
endpackage

// File: rtl/usd_seq_fsm.sv
module usd_seq_fsm
  import usd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              load_end,
  input  logic              prot_on,
  input  logic              lock_lo,
  input  logic              lock_hi,
  output logic              ev_id_in,
  output logic              ev_id_out,
  output logic              ev_lock_lo,
  output logic              ev_lock_hi,
  output logic              ev_erase,
  output logic              dec_write,
  output logic              dec_skip,
  output win_kind_e         dec_kind
);
  seq_st_e   st_q, st_d;
  win_kind_e kind_q, kind_d;
  logic      auth_q, auth_d, data_q, data_d, hit_q, hit_d;
  logic      at_ka, at_kb, in_lo, in_hi, blocked, plain, ok_win;

  always_comb begin
    at_ka   = (ld_addr[CMD_W-1:0] == KEY_A);
    at_kb   = (ld_addr[CMD_W-1:0] == KEY_B);
    in_lo   = (ld_addr[ADDR_W-1:BOOT_W] == '0);
    in_hi   = &ld_addr[ADDR_W-1:BOOT_W];
    blocked = (in_lo && lock_lo) || (in_hi && lock_hi);
  end

  always_comb begin
    st_d = st_q; kind_d = kind_q; auth_d = auth_q; data_d = data_q; hit_d = hit_q;
    plain = 1'b0;
    ev_id_in = 1'b0; ev_id_out = 1'b0; ev_lock_lo = 1'b0; ev_lock_hi = 1'b0; ev_erase = 1'b0;
    if (load_end) begin
      st_d = ST_IDLE; kind_d = WK_PLAIN; auth_d = 1'b0; data_d = 1'b0; hit_d = 1'b0;
    end else if (ld_valid) begin
      unique case (st_q)
        ST_IDLE: if (at_ka && ld_data == D_KA) st_d = ST_C1; else plain = 1'b1;
        ST_C1:   if (at_kb && ld_data == D_KB) st_d = ST_C2; else plain = 1'b1;
        ST_C2: begin
          if (!at_ka) plain = 1'b1;
          else begin
            case (ld_data)
              OP_PROT_ON: begin st_d = ST_DATA; kind_d = WK_SET; auth_d = 1'b1; end
              OP_ID_IN:   begin ev_id_in = 1'b1; st_d = ST_IDLE; end
              OP_ID_OUT:  begin ev_id_out = 1'b1; st_d = ST_IDLE; end
              OP_EXT:     st_d = ST_C3;
              default:    plain = 1'b1;
            endcase
          end
        end
        ST_C3:   if (at_ka && ld_data == D_KA) st_d = ST_C4; else plain = 1'b1;
        ST_C4:   if (at_kb && ld_data == D_KB) st_d = ST_C5; else plain = 1'b1;
        ST_C5: begin
          if (!at_ka) plain = 1'b1;
          else begin
            case (ld_data)
              OP_PROT_OF: begin st_d = ST_DATA; kind_d = WK_CLR; auth_d = 1'b1; end
              OP_LOCK:    st_d = ST_LOCK;
              OP_ERASE:   begin ev_erase = !(lock_lo || lock_hi); st_d = ST_IDLE; end
              default:    plain = 1'b1;
            endcase
          end
        end
        ST_LOCK: begin
          if (ld_addr == '0 && ld_data == 8'h00) begin
            ev_lock_lo = 1'b1; st_d = ST_IDLE;
          end else if (&ld_addr && ld_data == 8'hFF) begin
            ev_lock_hi = 1'b1; st_d = ST_IDLE;
          end else plain = 1'b1;
        end
        ST_DATA: begin data_d = 1'b1; hit_d = hit_q | blocked; end
        default: st_d = ST_IDLE;
      endcase
      if (plain) begin
        st_d = ST_DATA; kind_d = WK_PLAIN; auth_d = !prot_on; data_d = 1'b1; hit_d = blocked;
      end
    end
  end

  always_comb begin
    ok_win    = load_end && (st_q == ST_DATA) && data_q;
    dec_write = ok_win && auth_q && !hit_q;
    dec_skip  = ok_win && !(auth_q && !hit_q);
    dec_kind  = kind_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; kind_q <= WK_PLAIN; auth_q <= 1'b0; data_q <= 1'b0; hit_q <= 1'b0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; auth_q <= auth_d; data_q <= data_d; hit_q <= hit_d;
    end
  end

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    load_end |=> (st_q == ST_IDLE)); // R11
  AST_HIT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && hit_q && !load_end) |=> hit_q); // R10
endmodule

// File: rtl/usd_state_regs.sv
module usd_state_regs
  import usd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_id_in,
  input  logic      ev_id_out,
  input  logic      ev_lock_lo,
  input  logic      ev_lock_hi,
  input  logic      ev_erase,
  input  logic      dec_write,
  input  logic      dec_skip,
  input  win_kind_e dec_kind,
  input  logic      prog_end,
  output logic      prot_on,
  output logic      lock_lo,
  output logic      lock_hi,
  output logic      id_mode,
  output logic      sect_write,
  output logic      sect_skip,
  output logic      erase_go
);
  // Non-volatile flags: power-up value only, never touched by rst.
  logic prot_q = 1'b0;
  logic lo_q   = 1'b0;
  logic hi_q   = 1'b0;
  logic pend_on_q, pend_off_q, id_q, wr_q, sk_q, er_q;

  always_ff @(posedge clk) begin
    if (ev_lock_lo) lo_q <= 1'b1;
    if (ev_lock_hi) hi_q <= 1'b1;
    if (prog_end) begin
      if (pend_on_q)       prot_q <= 1'b1;
      else if (pend_off_q) prot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_on_q <= 1'b0; pend_off_q <= 1'b0; id_q <= 1'b0;
      wr_q <= 1'b0; sk_q <= 1'b0; er_q <= 1'b0;
    end else begin
      wr_q <= dec_write;
      sk_q <= dec_skip;
      er_q <= ev_erase;
      if (ev_id_in)       id_q <= 1'b1;
      else if (ev_id_out) id_q <= 1'b0;
      if (prog_end) begin
        pend_on_q <= 1'b0; pend_off_q <= 1'b0;
      end else if (dec_write) begin
        pend_on_q  <= (dec_kind == WK_SET);
        pend_off_q <= (dec_kind == WK_CLR);
      end
    end
  end

  assign prot_on    = prot_q;
  assign lock_lo    = lo_q;
  assign lock_hi    = hi_q;
  assign id_mode    = id_q;
  assign sect_write = wr_q;
  assign sect_skip  = sk_q;
  assign erase_go   = er_q;

  AST_PROT_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !prog_end |=> $stable(prot_q)); // R3
  AST_LOCK_LO_KEPT: assert property (@(posedge clk) disable iff (rst)
    lo_q |=> lo_q); // R8
  AST_LOCK_HI_KEPT: assert property (@(posedge clk) disable iff (rst)
    hi_q |=> hi_q); // R8
endmodule

// File: rtl/usd_id_mux.sv
module usd_id_mux
  import usd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic              lock_lo,
  input  logic              lock_hi,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rd_data
);
  localparam int BLK_W = ADDR_W - BOOT_W;
  localparam logic [ADDR_W-1:0] LO_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] HI_STAT = {{BLK_W{1'b1}}, {BOOT_W{1'b0}}} | ADDR_W'(2);

  logic [7:0] id_val, rd_q;

  always_comb begin
    if (rd_addr == '0)              id_val = ID_MFR;
    else if (rd_addr == ADDR_W'(1)) id_val = ID_DEV;
    else if (rd_addr == LO_STAT)    id_val = lock_lo ? ST_SHUT : ST_OPEN;
    else if (rd_addr == HI_STAT)    id_val = lock_hi ? ST_SHUT : ST_OPEN;
    else                            id_val = arr_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (id_mode) rd_q <= id_val;
    else              rd_q <= arr_rdata;
  end

  assign rd_data = rd_q;

  AST_ID_MFR_CODE: assert property (@(posedge clk) disable iff (rst)
    (id_mode && rd_addr == '0) |=> (rd_data == ID_MFR)); // R6
  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (rst)
    !id_mode |=> (rd_data == $past(arr_rdata))); // R9
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import usd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              load_end,
  input  logic              prog_end,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  output logic              sect_write,
  output logic              sect_skip,
  output logic              erase_go,
  output logic              prot_on,
  output logic              id_mode,
  output logic              lock_lo,
  output logic              lock_hi,
  output logic [7:0]        rd_data
);
  logic      ev_id_in, ev_id_out, ev_lock_lo, ev_lock_hi, ev_erase, dec_write, dec_skip;
  win_kind_e dec_kind;

  usd_seq_fsm #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_fsm (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .load_end(load_end), .prot_on(prot_on), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .ev_id_in(ev_id_in), .ev_id_out(ev_id_out), .ev_lock_lo(ev_lock_lo),
    .ev_lock_hi(ev_lock_hi), .ev_erase(ev_erase), .dec_write(dec_write),
    .dec_skip(dec_skip), .dec_kind(dec_kind)
  );

  usd_state_regs u_regs (
    .clk(clk), .rst(rst), .ev_id_in(ev_id_in), .ev_id_out(ev_id_out),
    .ev_lock_lo(ev_lock_lo), .ev_lock_hi(ev_lock_hi), .ev_erase(ev_erase),
    .dec_write(dec_write), .dec_skip(dec_skip), .dec_kind(dec_kind), .prog_end(prog_end),
    .prot_on(prot_on), .lock_lo(lock_lo), .lock_hi(lock_hi), .id_mode(id_mode),
    .sect_write(sect_write), .sect_skip(sect_skip), .erase_go(erase_go)
  );

  usd_id_mux #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_mux (
    .clk(clk), .rst(rst), .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data)
  );
endmodule

// File: tb/unlock_seq_decoder_bench.sv
module unlock_seq_decoder_bench;
  localparam int AW = 19;
  localparam logic [AW-1:0] TOP_STAT = 19'h7C002;

  logic clk = 1'b0, rst = 1'b1, ld_valid = 1'b0, load_end = 1'b0, prog_end = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [7:0] ld_data = '0, arr_rdata = '0;
  logic sect_write, sect_skip, erase_go, prot_on, id_mode, lock_lo, lock_hi;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic m_lo = 0, m_hi = 0;

  always #4 clk = ~clk;

  unlock_seq_decoder u_unlock_seq_decoder (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .load_end(load_end), .prog_end(prog_end), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .sect_write(sect_write), .sect_skip(sect_skip), .erase_go(erase_go), .prot_on(prot_on),
    .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_expect(input logic [AW-1:0] a, input logic [7:0] arr,
                                           input logic idm, input logic lo, input logic hi);
    if (!idm) return arr;
    if (a == 0) return 8'h1F;
    if (a == 1) return 8'hA4;
    if (a == 2) return lo ? 8'hFF : 8'hFE;
    if (a == TOP_STAT) return hi ? 8'hFF : 8'hFE;
    return arr;
  endfunction

  task automatic ld(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic pfx(input logic [7:0] op);
    ld(19'h05555, 8'hAA); ld(19'h02AAA, 8'h55); ld(19'h05555, op);
  endtask

  task automatic ext(input logic [7:0] op);
    pfx(8'h80); ld(19'h05555, 8'hAA); ld(19'h02AAA, 8'h55); ld(19'h05555, op);
  endtask

  task automatic burst(input logic [4:0] blk, input int n);
    for (int i = 0; i < n; i++) ld({blk, 14'($urandom)}, 8'($urandom) | 8'h01);
  endtask

  task automatic finish_load(input logic ew, input logic es, input string req);
    @(negedge clk); load_end = 1'b1;
    @(negedge clk); load_end = 1'b0;
    check({req, " write verdict"}, 32'(sect_write), 32'(ew));
    check({req, " skip verdict"}, 32'(sect_skip), 32'(es));
  endtask

  task automatic prog_finish;
    @(negedge clk); prog_end = 1'b1;
    @(negedge clk); prog_end = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    logic [7:0] arr;
    arr = 8'($urandom);
    @(negedge clk); rd_addr = a; arr_rdata = arr;
    @(negedge clk);
    check(req, 32'(rd_data), 32'(id_expect(a, arr, id_mode, m_lo, m_hi)));
  endtask

  function automatic logic [4:0] mid_blk;
    return 5'(1 + $urandom_range(29));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R13 reset id_mode", 32'(id_mode), 0);
    check("R13 reset prot_on", 32'(prot_on), 0);
    check("R8 reset locks", {30'b0, lock_hi, lock_lo}, 0);
    check("R2 reset verdict", {30'b0, sect_write, sect_skip}, 0);

    // R4 unprotected plain loads, random sectors
    for (int k = 0; k < 4; k++) begin
      burst(mid_blk(), 2 + k);
      finish_load(1, 0, "R4 plain unprotected");
      prog_finish;
      check("R4 prot unchanged", 32'(prot_on), 0);
    end
    @(negedge clk);
    check("R2 pulse is one cycle", 32'(sect_write), 0);

    // R11 broken sequence becomes data
    ld(19'h05555, 8'hAA); ld(19'h01234, 8'h12);
    finish_load(1, 0, "R11 broken sequence as data");
    prog_finish;
    // R11 empty window
    pfx(8'hA0);
    finish_load(0, 0, "R11 empty window");
    prog_finish;
    check("R3 no data no protect", 32'(prot_on), 0);

    // R1 high address bits ignored; R2 and R3
    ld(19'h7D555, 8'hAA); ld(19'h42AAA, 8'h55); ld(19'h35555, 8'hA0);
    burst(mid_blk(), 3);
    finish_load(1, 0, "R1 R2 prefixed load");
    check("R3 prot waits for prog_end", 32'(prot_on), 0);
    prog_finish;
    check("R3 prot set at prog_end", 32'(prot_on), 1);

    // R4 protected unprefixed loads skipped
    for (int k = 0; k < 3; k++) begin
      burst(mid_blk(), 3);
      finish_load(0, 1, "R4 protected unprefixed");
      prog_finish;
    end

    // R13 reset mid-sequence
    ld(19'h05555, 8'hAA);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ld(19'h02AAA, 8'h55); ld(19'h05555, 8'h90);
    check("R13 partial sequence dropped", 32'(id_mode), 0);
    check("R13 prot kept", 32'(prot_on), 1);
    finish_load(0, 1, "R13 post-reset load");
    prog_finish;

    // R2 prefixed while protected
    pfx(8'hA0); burst(mid_blk(), 4);
    finish_load(1, 0, "R2 protected prefixed");
    prog_finish;
    check("R3 prot stays", 32'(prot_on), 1);

    // R6 ID mode and R9 reads
    pfx(8'h90);
    check("R6 id_mode set", 32'(id_mode), 1);
    rd(19'h00000, "R6 manufacturer code");
    rd(19'h00001, "R6 device code");
    rd(19'h00002, "R9 lower status open");
    rd(TOP_STAT, "R9 upper status open");
    for (int k = 0; k < 4; k++) rd(19'h00010 + 19'($urandom_range(4000)), "R9 id other address");
    pfx(8'hF0);
    check("R7 id_mode cleared", 32'(id_mode), 0);
    rd(19'h00000, "R7 array after exit");
    for (int k = 0; k < 3; k++) rd(19'($urandom), "R9 array pass");

    // R12 erase unlocked
    ext(8'h10);
    check("R12 erase when unlocked", 32'(erase_go), 1);
    @(negedge clk);
    check("R12 erase pulse one cycle", 32'(erase_go), 0);

    // R8 lower lock
    ext(8'h40); ld(19'h00000, 8'h00); m_lo = 1;
    check("R8 lock_lo set", 32'(lock_lo), 1);
    check("R8 lock_hi independent", 32'(lock_hi), 0);
    pfx(8'hA0); burst(5'd0, 3);
    finish_load(0, 1, "R10 lower locked");
    prog_finish;
    pfx(8'hA0); burst(mid_blk(), 2); burst(5'd0, 1);
    finish_load(0, 1, "R10 late locked byte");
    prog_finish;
    pfx(8'hA0); burst(5'h1F, 2);
    finish_load(1, 0, "R10 upper still open");
    prog_finish;

    pfx(8'h90);
    rd(19'h00002, "R9 lower status locked");
    rd(TOP_STAT, "R9 upper status open");
    pfx(8'hF0);

    // R8 upper lock
    ext(8'h40); ld(19'h7FFFF, 8'hFF); m_hi = 1;
    check("R8 lock_hi set", 32'(lock_hi), 1);
    check("R8 lock_lo kept", 32'(lock_lo), 1);
    pfx(8'hA0); burst(5'h1F, 2);
    finish_load(0, 1, "R10 upper locked");
    prog_finish;
    ext(8'h10);
    check("R12 no erase when locked", 32'(erase_go), 0);

    // R5 disable sequence
    ext(8'h20); burst(mid_blk(), 3);
    finish_load(1, 0, "R5 disable load");
    check("R5 prot held until prog_end", 32'(prot_on), 1);
    prog_finish;
    check("R5 prot cleared", 32'(prot_on), 0);
    burst(mid_blk(), 2);
    finish_load(1, 0, "R4 unprotected again");
    prog_finish;

    // R13 locks survive reset, id mode cleared
    pfx(8'h90);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R13 id cleared by reset", 32'(id_mode), 0);
    check("R13 locks kept", {30'b0, lock_hi, lock_lo}, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule